// File: doc/BRIEF.md
# Capture Timing Calibration Sweep Controller

This controller finds a reliable capture point for a source-synchronous data input. It drives a delay tap through every setting, first with the capture clock at normal polarity. For each tap it waits for the delay line to take the new setting, lets the link settle for a programmable number of cycles, and then records whether an external pattern checker reports clean data. From the recorded verdicts it finds the widest run of adjacent passing taps and takes the tap at the centre of that run.

A narrow window at normal polarity is not trusted. In that case the sweep is repeated with the capture clock inverted, and the better of the two polarities is kept. The chosen tap and polarity are programmed through the same request/acknowledge handshake used during the sweep. After that, a single-cycle done strobe is raised. If no tap passed at either polarity, done is raised together with an error flag.

The complete verdict map stays on an output port after the run, so it can be inspected. The delay line, the polarity switch and the pattern checker are all outside this block.

Top module: `dlycal_sweep`

## Requirements
- R1: After reset, `tapReq`, `done`, `calErr` and `invPol` are 0 and every bit of `failMap` is 1.
- R2: A `startCal` pulse accepted while idle sets every bit of `failMap` to 1 (fail) before any tap is recorded. A half that is not swept in that run therefore reads all ones afterwards.
- R3: Each tap is applied by holding `tapReq` high, with `tapOut` and `invPol` stable, until `tapAck` is sampled high. Normal polarity (`invPol`=0) is swept first over taps 0, 1, … NUM_TAPS-1 in rising order. An inverted sweep, when it happens, uses `invPol`=1 over the same order.
- R4: The checker input `chkPass` is sampled once per tap, exactly settleCycles+2 clock edges after the edge that accepted the tap acknowledge. Values present earlier are not used.
- R5: For normal tap k, `failMap[k]` holds the inverse of the sampled `chkPass`. For inverted tap k, `failMap[NUM_TAPS+k]` holds it. A 1 means fail.
- R6: Within one polarity, the window is the longest run of adjacent passing taps, and the earliest run wins a tie in length. The candidate tap is the run's first tap plus floor(run length / 2).
- R7: If the normal-polarity window is at least MIN_RUN (default 3) taps long, its candidate is chosen with `invPol`=0 and no inverted sweep is made.
- R8: Otherwise the inverted sweep runs. Inverted polarity and its candidate are chosen when its window length is greater than or equal to the normal one. If it is not, `invPol` returns to 0 and the normal candidate is chosen.
- R9: If both polarities have no passing tap, `calErr` and `done` rise together and no final tap is applied.
- R10: On success, the chosen tap and polarity are applied through the handshake before `done` rises. `done` lasts exactly one cycle, and `failMap`, `tapOut` and `invPol` keep their values afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| startCal | input | 1 | Pulse that starts a calibration while idle |
| settleCycles | input | SETTLE_W | Extra wait cycles between tap acknowledge and checker sampling |
| tapAck | input | 1 | Delay line has taken `tapOut` / `invPol` |
| chkPass | input | 1 | Pattern checker verdict, 1 = clean data |
| tapReq | output | 1 | Request to program `tapOut` and `invPol` |
| tapOut | output | TAP_W | Tap setting; valid while `tapReq` is high and after `done` |
| invPol | output | 1 | Capture clock polarity, 1 = inverted |
| done | output | 1 | One-cycle end-of-calibration strobe |
| calErr | output | 1 | No passing tap found; held until the next start |
| failMap | output | 2*NUM_TAPS | Per-tap fail map, normal half low, inverted half high |

## Verification
The bench builds the block with its default parameters: 32 taps per polarity, an 8-bit settle count and a minimum window of 3. It sweeps the settle count from 0 to 3. Its checker model returns the wrong verdict until exactly settleCycles+1 cycles after an acknowledge, so a sample taken one cycle early corrupts the map. Hand-picked verdict patterns hit the window edge cases: a window of exactly 3, a tie between polarities, equal-length runs within one polarity, runs touching tap 0 and tap 31, all-pass, and all-fail. A further set of pseudo-random patterns is checked against an arithmetic model of the run search.

// File: rtl/dlycal_pkg.sv
package dlycal_pkg;

  typedef struct packed {
    logic clrAll;
    logic record;
    logic scanClr;
    logic scanStep;
    logic saveRes;
  } dlycal_stb_t;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_APPLY,
    ST_SETTLE,
    ST_SAMPLE,
    ST_SCAN,
    ST_SAVE,
    ST_DECIDE,
    ST_FINAL
  } dlycal_state_t;

endpackage

// File: rtl/dlycal_datapath.sv
module dlycal_datapath
  import dlycal_pkg::*;
#(
  parameter int NUM_TAPS = 32,
  parameter int TAP_W    = $clog2(NUM_TAPS),
  parameter int LEN_W    = TAP_W + 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  dlycal_stb_t           stb,
  input  logic                  pol,
  input  logic [TAP_W-1:0]      idx,
  input  logic                  chkPass,
  output logic [2*NUM_TAPS-1:0] failMap,
  output logic [LEN_W-1:0]      normLen,
  output logic [TAP_W-1:0]      normMid,
  output logic [LEN_W-1:0]      invLen,
  output logic [TAP_W-1:0]      invMid
);

  // NUM_TAPS is a power of two, so {pol, idx} addresses the map directly
  logic [TAP_W:0]       bitIdx;
  logic [LEN_W-1:0]     curLen, bestLen, runNext;
  logic [TAP_W-1:0]     curStart, bestStart, runStart, midCalc;
  logic                 tapPass;

  assign bitIdx   = {pol, idx};
  assign tapPass  = ~failMap[bitIdx];
  assign runNext  = curLen + LEN_W'(1);
  assign runStart = (curLen == '0) ? idx : curStart;
  assign midCalc  = bestStart + TAP_W'(bestLen >> 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      failMap   <= '1;
      normLen   <= '0;
      normMid   <= '0;
      invLen    <= '0;
      invMid    <= '0;
      curLen    <= '0;
      bestLen   <= '0;
      curStart  <= '0;
      bestStart <= '0;
    end else begin
      if (stb.clrAll) begin
        failMap <= '1;
        normLen <= '0;
        normMid <= '0;
        invLen  <= '0;
        invMid  <= '0;
      end
      if (stb.record) failMap[bitIdx] <= ~chkPass;
      if (stb.scanClr) begin
        curLen    <= '0;
        bestLen   <= '0;
        curStart  <= '0;
        bestStart <= '0;
      end else if (stb.scanStep) begin
        if (tapPass) begin
          curLen   <= runNext;
          curStart <= runStart;
          // strict compare keeps the earliest run on a length tie
          if (runNext > bestLen) begin
            bestLen   <= runNext;
            bestStart <= runStart;
          end
        end else begin
          curLen <= '0;
        end
      end
      if (stb.saveRes) begin
        if (pol) begin
          invLen <= bestLen;
          invMid <= midCalc;
        end else begin
          normLen <= bestLen;
          normMid <= midCalc;
        end
      end
    end
  end

endmodule

// File: rtl/dlycal_ctrl.sv
module dlycal_ctrl
  import dlycal_pkg::*;
#(
  parameter int NUM_TAPS = 32,
  parameter int SETTLE_W = 8,
  parameter int MIN_RUN  = 3,
  parameter int TAP_W    = $clog2(NUM_TAPS),
  parameter int LEN_W    = TAP_W + 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                startCal,
  input  logic [SETTLE_W-1:0] settleCycles,
  input  logic                tapAck,
  input  logic [LEN_W-1:0]    normLen,
  input  logic [TAP_W-1:0]    normMid,
  input  logic [LEN_W-1:0]    invLen,
  input  logic [TAP_W-1:0]    invMid,
  output dlycal_stb_t         stb,
  output logic [TAP_W-1:0]    tap,
  output logic                pol,
  output logic                tapReq,
  output logic                done,
  output logic                calErr
);

  localparam logic [TAP_W-1:0] LAST_TAP = TAP_W'(NUM_TAPS - 1);
  localparam logic [LEN_W-1:0] MIN_LEN  = LEN_W'(MIN_RUN);

  dlycal_state_t       state;
  logic [SETTLE_W-1:0] settleCnt;

  assign tapReq = (state == ST_APPLY) || (state == ST_FINAL);

  always_comb begin
    stb          = '0;
    stb.clrAll   = (state == ST_IDLE) && startCal;
    stb.record   = (state == ST_SAMPLE);
    stb.scanClr  = (state == ST_SAMPLE) && (tap == LAST_TAP);
    stb.scanStep = (state == ST_SCAN);
    stb.saveRes  = (state == ST_SAVE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      tap       <= '0;
      pol       <= 1'b0;
      settleCnt <= '0;
      done      <= 1'b0;
      calErr    <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: if (startCal) begin
          tap    <= '0;
          pol    <= 1'b0;
          calErr <= 1'b0;
          state  <= ST_APPLY;
        end
        ST_APPLY: if (tapAck) begin
          settleCnt <= '0;
          state     <= ST_SETTLE;
        end
        ST_SETTLE: begin
          if (settleCnt == settleCycles) state <= ST_SAMPLE;
          else settleCnt <= settleCnt + SETTLE_W'(1);
        end
        ST_SAMPLE: begin
          if (tap == LAST_TAP) begin
            tap   <= '0;
            state <= ST_SCAN;
          end else begin
            tap   <= tap + TAP_W'(1);
            state <= ST_APPLY;
          end
        end
        ST_SCAN: begin
          if (tap == LAST_TAP) state <= ST_SAVE;
          else tap <= tap + TAP_W'(1);
        end
        ST_SAVE: state <= ST_DECIDE;
        ST_DECIDE: begin
          if (!pol) begin
            if (normLen >= MIN_LEN) begin
              tap   <= normMid;
              state <= ST_FINAL;
            end else begin
              pol   <= 1'b1;
              tap   <= '0;
              state <= ST_APPLY;
            end
          end else if (normLen == '0 && invLen == '0) begin
            calErr <= 1'b1;
            done   <= 1'b1;
            state  <= ST_IDLE;
          end else if (invLen >= normLen) begin
            tap   <= invMid;
            state <= ST_FINAL;
          end else begin
            pol   <= 1'b0;
            tap   <= normMid;
            state <= ST_FINAL;
          end
        end
        ST_FINAL: if (tapAck) begin
          done  <= 1'b1;
          state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/dlycal_sweep.sv
module dlycal_sweep
  import dlycal_pkg::*;
#(
  parameter int NUM_TAPS = 32,
  parameter int SETTLE_W = 8,
  parameter int MIN_RUN  = 3,
  parameter int TAP_W    = $clog2(NUM_TAPS),
  parameter int LEN_W    = TAP_W + 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  startCal,
  input  logic [SETTLE_W-1:0]   settleCycles,
  input  logic                  tapAck,
  input  logic                  chkPass,
  output logic                  tapReq,
  output logic [TAP_W-1:0]      tapOut,
  output logic                  invPol,
  output logic                  done,
  output logic                  calErr,
  output logic [2*NUM_TAPS-1:0] failMap
);

  dlycal_stb_t      stb;
  logic [LEN_W-1:0] normLen, invLen;
  logic [TAP_W-1:0] normMid, invMid;

  dlycal_ctrl #(
    .NUM_TAPS(NUM_TAPS), .SETTLE_W(SETTLE_W), .MIN_RUN(MIN_RUN),
    .TAP_W(TAP_W), .LEN_W(LEN_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .startCal(startCal),
    .settleCycles(settleCycles), .tapAck(tapAck),
    .normLen(normLen), .normMid(normMid), .invLen(invLen), .invMid(invMid),
    .stb(stb), .tap(tapOut), .pol(invPol), .tapReq(tapReq),
    .done(done), .calErr(calErr)
  );

  dlycal_datapath #(
    .NUM_TAPS(NUM_TAPS), .TAP_W(TAP_W), .LEN_W(LEN_W)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .stb(stb), .pol(invPol), .idx(tapOut),
    .chkPass(chkPass), .failMap(failMap),
    .normLen(normLen), .normMid(normMid), .invLen(invLen), .invMid(invMid)
  );

endmodule

// File: rtl/dlycal_sweep_chk.sv
module dlycal_sweep_chk #(
  parameter int NUM_TAPS = 32,
  parameter int SETTLE_W = 8,
  parameter int TAP_W    = $clog2(NUM_TAPS)
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  startCal,
  input logic [SETTLE_W-1:0]   settleCycles,
  input logic                  tapAck,
  input logic                  tapReq,
  input logic [TAP_W-1:0]      tapOut,
  input logic                  invPol,
  input logic                  done,
  input logic                  calErr,
  input logic [2*NUM_TAPS-1:0] failMap
);

  localparam int CNT_W = SETTLE_W + 2;

  logic [CNT_W-1:0] sinceAck;
  logic [CNT_W-1:0] minGap;

  assign minGap = CNT_W'(settleCycles) + CNT_W'(2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sinceAck <= '0;
    else if (tapReq && tapAck) sinceAck <= '0;
    else if (sinceAck != '1) sinceAck <= sinceAck + CNT_W'(1);
  end

  a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r10_no_req_at_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !tapReq);

  a_r3_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (tapReq && !tapAck) |=> (tapReq && $stable(tapOut) && $stable(invPol)));

  a_r9_err_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(calErr) |-> done);

  a_r4_settle_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(failMap) && !$past(startCal)) |-> (sinceAck >= minGap));

endmodule

bind dlycal_sweep dlycal_sweep_chk #(
  .NUM_TAPS(NUM_TAPS), .SETTLE_W(SETTLE_W), .TAP_W(TAP_W)
) u_chk (.*);

// File: tb/dlycal_sweep_tb.sv
`timescale 1ns/1ps
module dlycal_sweep_tb;

  localparam int NT = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          startCal = 1'b0;
  logic [7:0]    settleCycles = '0;
  logic          tapAck = 1'b0;
  logic          chkPass = 1'b0;
  logic          tapReq;
  logic [4:0]    tapOut;
  logic          invPol;
  logic          done;
  logic          calErr;
  logic [63:0]   failMap;

  int nChecks = 0;
  int nFails  = 0;

  logic [31:0] patN = '0, patI = '0;
  int          settleS = 0;
  int          appN = 0;
  int          appT [0:79];
  bit          appP [0:79];
  int          curTap = 0;
  bit          curPol = 1'b0;
  int          sinceAck = 0;

  always #5 clk = ~clk;

  dlycal_sweep u_dut (
    .clk(clk), .rst_n(rst_n), .startCal(startCal), .settleCycles(settleCycles),
    .tapAck(tapAck), .chkPass(chkPass), .tapReq(tapReq), .tapOut(tapOut),
    .invPol(invPol), .done(done), .calErr(calErr), .failMap(failMap)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // delay line and pattern checker model; verdict is wrong until settled (R4)
  initial begin
    forever begin
      @(negedge clk);
      if (!rst_n) begin
        tapAck = 1'b0;
        sinceAck = 0;
      end else begin
        if (tapAck) sinceAck = 0;
        else sinceAck++;
        if (tapReq && !tapAck) begin
          tapAck = 1'b1;
          curTap = int'(tapOut);
          curPol = invPol;
          if (appN < 80) begin
            appT[appN] = curTap;
            appP[appN] = curPol;
          end
          appN++;
        end else begin
          tapAck = 1'b0;
        end
        if (!tapAck && sinceAck >= settleS + 1)
          chkPass = curPol ? patI[curTap] : patN[curTap];
        else
          chkPass = curPol ? ~patI[curTap] : ~patN[curTap];
      end
    end
  end

  function automatic void bestRun(input logic [31:0] p, output int len, output int mid);
    int cur, st, bs;
    cur = 0; st = 0; bs = 0; len = 0;
    for (int i = 0; i < NT; i++) begin
      if (p[i]) begin
        if (cur == 0) st = i;
        cur++;
        if (cur > len) begin
          len = cur;
          bs = st;
        end
      end else begin
        cur = 0;
      end
    end
    mid = bs + len / 2;
  endfunction

  task automatic runCal(input logic [31:0] pn, input logic [31:0] pi, input int s,
                        input string tag);
    int w, nl, nm, il, im, expTap, expApps;
    bit expPol, expErr, swept, seqOk;
    logic [63:0] expMap, mapAtDone;
    patN = pn; patI = pi; settleS = s; settleCycles = 8'(s);
    @(negedge clk);
    appN = 0;
    startCal = 1'b1;
    @(negedge clk);
    startCal = 1'b0;
    w = 0;
    while (!done && w < 20000) begin
      @(negedge clk);
      w++;
    end
    if (!done) begin
      check(1'b0, "R10", {tag, " done never seen"}, 64'(w), 64'(0));
      return;
    end
    bestRun(pn, nl, nm);
    il = 0; im = 0;
    expErr = 1'b0;
    swept = (nl < 3);
    if (!swept) begin
      expPol = 1'b0; expTap = nm;
      expMap = {32'hFFFF_FFFF, ~pn};
      expApps = NT + 1;
    end else begin
      bestRun(pi, il, im);
      expMap = {~pi, ~pn};
      if (nl == 0 && il == 0) begin
        expErr = 1'b1; expPol = 1'b1; expTap = 0;
        expApps = 2 * NT;
      end else begin
        expApps = 2 * NT + 1;
        if (il >= nl) begin expPol = 1'b1; expTap = im; end
        else begin expPol = 1'b0; expTap = nm; end
      end
    end
    // R5 map contents; R2 untouched half reads all fail
    check(failMap[31:0] == expMap[31:0], "R5", {tag, " normal half"},
          64'(failMap[31:0]), 64'(expMap[31:0]));
    check(failMap[63:32] == expMap[63:32], swept ? "R5" : "R2", {tag, " inverted half"},
          64'(failMap[63:32]), 64'(expMap[63:32]));
    // R7/R8/R9 number of taps applied tells which sweeps ran
    check(appN == expApps, swept ? "R8" : "R7", {tag, " applied tap count"},
          64'(appN), 64'(expApps));
    check(calErr == expErr, "R9", {tag, " error flag"}, 64'(calErr), 64'(expErr));
    seqOk = 1'b1;
    for (int k = 0; k < NT; k++) begin
      if (appT[k] != k || appP[k] != 1'b0) seqOk = 1'b0;
      if (swept && (appT[NT + k] != k || appP[NT + k] != 1'b1)) seqOk = 1'b0;
    end
    check(seqOk, "R3", {tag, " sweep order"}, 64'(seqOk), 64'(1));
    if (!expErr) begin
      check(tapOut == 5'(expTap) && invPol == expPol, "R6",
            {tag, " chosen tap/polarity"}, {58'd0, invPol, tapOut},
            {58'd0, expPol, 5'(expTap)});
      check(appN == expApps && appT[expApps-1] == expTap && appP[expApps-1] == expPol,
            "R10", {tag, " final tap applied before done"},
            64'(appT[expApps-1]), 64'(expTap));
    end
    mapAtDone = failMap;
    @(negedge clk);
    check(!done && failMap == mapAtDone, "R10", {tag, " done single cycle, map kept"},
          {63'd0, done}, 64'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "R10", "watchdog expired", 64'd0, 64'd1);
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    logic [31:0] lfsrA, lfsrB;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(!tapReq && !done && !calErr && !invPol, "R1", "control outputs at reset",
          {60'd0, tapReq, done, calErr, invPol}, 64'd0);
    check(failMap == '1, "R1", "map at reset", failMap, '1);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(!tapReq && !done, "R1", "idle after reset", {62'd0, tapReq, done}, 64'd0);

    runCal(32'h001F_FFE0, 32'h0, 0, "wide window");               // R6 R7
    runCal(32'h0000_1C00, 32'h0, 1, "run of three");              // R7 boundary
    runCal(32'h0000_0300, 32'h0000_03F0, 2, "inverted wins");     // R8
    runCal(32'h0000_0003, 32'h0000_0100, 3, "normal kept");       // R8
    runCal(32'h0000_0006, 32'h0000_C000, 1, "polarity tie");      // R8
    runCal(32'h0, 32'h0, 0, "all fail");                          // R9
    runCal(32'h0000_3C0F, 32'h0, 2, "equal runs");                // R6 earliest
    runCal(32'hFFFF_FFFF, 32'h0, 0, "all pass");                  // R6
    runCal(32'h0, 32'h8000_0000, 1, "last tap only");             // R8
    runCal(32'hF000_0000, 32'h0, 3, "run at top");                // R6
    runCal(32'h0000_0050, 32'h0, 0, "isolated passes");           // R8 after R2
    runCal(32'h0000_0F00, 32'h0, 1, "map preset again");          // R2

    lfsrA = 32'hACE1_2345;
    lfsrB = 32'h1357_9BDF;
    for (int n = 0; n < 24; n++) begin
      for (int j = 0; j < 7; j++) begin
        lfsrA = {lfsrA[30:0], lfsrA[31] ^ lfsrA[21] ^ lfsrA[1] ^ lfsrA[0]};
        lfsrB = {lfsrB[30:0], lfsrB[31] ^ lfsrB[21] ^ lfsrB[1] ^ lfsrB[0]};
      end
      runCal(lfsrA & lfsrB & (lfsrA >> 1), lfsrA | lfsrB, n % 4, "pseudo-random");
    end

    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule